// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block is the register core of an eight-pin general-purpose I/O port. A host programs it over a plain parallel register bus: an address, a write strobe, a read strobe, and write and read data. The block stores these settings for each pin: direction, output level, input polarity inversion, pull enable, pull direction and a two-bit drive-strength code. It also stores one output-stage mode bit that applies to the whole port. From these settings it drives the pad control lines: output enable, output value, open-drain flag, pull enable, pull direction and drive code.

The block samples the pad input levels into an input register on every clock. The polarity mask is applied to that register to produce the corrected input value. This value is always present on a port and is also returned when the input address is read. The serial-bus front end, interrupt generation and analog pad behaviour belong to other blocks.

Register map (byte-wide data, 4-bit address): 0 input (read-only), 1 output level, 2 polarity, 3 direction, 4 drive code bit 0, 5 drive code bit 1, 6 pull enable, 7 pull direction (1 = up), 8 output mode (bit 0, 1 = open-drain). All other addresses are unmapped.

Top module: `gpio_port_bank`

## Requirements
- R1: After synchronous reset, every pin is an input: the direction register is 0xFF and pad_oe is 0. The other reset values are output 0xFF, polarity 0x00, both drive-code registers 0xFF, pull enable 0x00, pull direction 0xFF and mode 0 (push-pull).
- R2: A write to a mapped writable address takes effect at the clock edge that samples reg_wr. When reg_rd is sampled, reg_rdata is loaded with that address's content at the same edge, and reg_rdata holds its value while reg_rd is low. The mode address reads back with bits 7..1 as zero.
- R3: pad_in is sampled into the input register on every clock edge. in_value, and a read of address 0, give that register XOR the polarity register, so a polarity bit of 1 inverts that pin.
- R4: Address 0 is read-only, and a write to it changes no register.
- R5: In push-pull mode (mode bit 0), pad_oe equals the inverse of the direction register (1 = input, 0 = output), and pad_out equals the output register.
- R6: In open-drain mode (mode bit 1), pad_out is all zero. A pin set as an output has pad_oe high only when its output bit is 0. pad_od mirrors the mode bit.
- R7: For pin i, pad_drive[2i+1:2i] equals {drive bit 1 register[i], drive bit 0 register[i]}.
- R8: pad_pull_en and pad_pull_up equal the pull enable and pull direction registers.
- R9: The output register keeps its value until address 1 is written again. Reads and writes to other addresses do not change it.
- R10: A read of an unmapped address (9 to 15) returns 0x00, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable, one per pin |
| pad_out | output | 8 | Pad output value |
| pad_od | output | 1 | Open-drain mode for the port |
| pad_pull_en | output | 8 | Pull resistor enable |
| pad_pull_up | output | 8 | Pull direction, 1 = up, 0 = down |
| pad_drive | output | 16 | Drive-strength code, two bits per pin |
| in_value | output | 8 | Polarity-corrected input register |

## Verification
Pad control outputs depend only on register state, so they change one clock edge after the write that alters them. The bench drives a write on a falling edge and checks the pads at the next falling edge. Read data is due at the edge that samples reg_rd and is compared one half-period later. A pad_in change needs one edge to reach the input register, so the bench waits one full cycle after changing pads before it checks in_value or reads address 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PINS   = 8;
    localparam int AW     = 4;
    localparam int DRV_W  = 2;
    localparam int DRIVE_W = PINS * DRV_W;

    typedef enum logic [AW-1:0] {
        A_IN   = 4'd0,
        A_OUT  = 4'd1,
        A_POL  = 4'd2,
        A_CFG  = 4'd3,
        A_DRVL = 4'd4,
        A_DRVH = 4'd5,
        A_PEN  = 4'd6,
        A_PSEL = 4'd7,
        A_MODE = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic            od_mode;
        logic [PINS-1:0] out_v;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] cfg;
        logic [PINS-1:0] drv_lo;
        logic [PINS-1:0] drv_hi;
        logic [PINS-1:0] pull_en;
        logic [PINS-1:0] pull_sel;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{
        od_mode:  1'b0,
        out_v:    '1,
        pol:      '0,
        cfg:      '1,
        drv_lo:   '1,
        drv_hi:   '1,
        pull_en:  '0,
        pull_sel: '1
    };

    function automatic logic [DRV_W-1:0] drv_code(input port_cfg_t c, input int i);
        return {c.drv_hi[i], c.drv_lo[i]};
    endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pad_in,
    output port_cfg_t       cfg_q,
    output logic [PINS-1:0] in_q
);
    port_cfg_t s;

    always_ff @(posedge clk) begin
        if (rst) begin
            s <= CFG_RESET;
        end else if (wr_en) begin
            case (addr)
                A_OUT:  s.out_v    <= wdata;
                A_POL:  s.pol      <= wdata;
                A_CFG:  s.cfg      <= wdata;
                A_DRVL: s.drv_lo   <= wdata;
                A_DRVH: s.drv_hi   <= wdata;
                A_PEN:  s.pull_en  <= wdata;
                A_PSEL: s.pull_sel <= wdata;
                A_MODE: s.od_mode  <= wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        in_q <= pad_in;
    end

    assign cfg_q = s;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_OUT) |=> $stable(s.out_v));

    // R4
    in_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_IN) |=> $stable(s));

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr > A_MODE) |=> $stable(s));

    // R3
    in_smp_chk: assert property (@(posedge clk) disable iff (rst)
        in_q == $past(pad_in));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
(
    input  port_cfg_t          cfg_q,
    output logic [PINS-1:0]    pad_oe,
    output logic [PINS-1:0]    pad_out,
    output logic               pad_od,
    output logic [PINS-1:0]    pad_pull_en,
    output logic [PINS-1:0]    pad_pull_up,
    output logic [DRIVE_W-1:0] pad_drive
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign pad_oe[i]  = ~cfg_q.cfg[i] & (~cfg_q.od_mode | ~cfg_q.out_v[i]);
        assign pad_out[i] = cfg_q.out_v[i] & ~cfg_q.od_mode;
        assign pad_drive[DRV_W*i +: DRV_W] = drv_code(cfg_q, i);
    end

    assign pad_od      = cfg_q.od_mode;
    assign pad_pull_en = cfg_q.pull_en;
    assign pad_pull_up = cfg_q.pull_sel;
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            rd_en,
    input  port_cfg_t       cfg_q,
    input  logic [PINS-1:0] in_q,
    output logic [PINS-1:0] in_corr,
    output logic [PINS-1:0] rdata
);
    logic [PINS-1:0] sel;

    assign in_corr = in_q ^ cfg_q.pol;

    always_comb begin
        case (addr)
            A_IN:    sel = in_corr;
            A_OUT:   sel = cfg_q.out_v;
            A_POL:   sel = cfg_q.pol;
            A_CFG:   sel = cfg_q.cfg;
            A_DRVL:  sel = cfg_q.drv_lo;
            A_DRVH:  sel = cfg_q.drv_hi;
            A_PEN:   sel = cfg_q.pull_en;
            A_PSEL:  sel = cfg_q.pull_sel;
            A_MODE:  sel = {{(PINS-1){1'b0}}, cfg_q.od_mode};
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= sel;
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R10
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr > A_MODE) |=> rdata == '0);
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [PINS-1:0]    reg_wdata,
    output logic [PINS-1:0]    reg_rdata,
    input  logic [PINS-1:0]    pad_in,
    output logic [PINS-1:0]    pad_oe,
    output logic [PINS-1:0]    pad_out,
    output logic               pad_od,
    output logic [PINS-1:0]    pad_pull_en,
    output logic [PINS-1:0]    pad_pull_up,
    output logic [DRIVE_W-1:0] pad_drive,
    output logic [PINS-1:0]    in_value
);
    port_cfg_t       cfg_q;
    logic [PINS-1:0] in_q;

    gpio_cfg_regs u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr_en(reg_wr),
        .wdata(reg_wdata), .pad_in(pad_in), .cfg_q(cfg_q), .in_q(in_q)
    );

    gpio_pad_drive u_pads (
        .cfg_q(cfg_q), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_drive(pad_drive)
    );

    gpio_rd_path u_rd (
        .clk(clk), .rst(rst), .addr(reg_addr), .rd_en(reg_rd),
        .cfg_q(cfg_q), .in_q(in_q), .in_corr(in_value), .rdata(reg_rdata)
    );

    // R5
    oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & cfg_q.cfg) == '0);

    // R6
    od_release_chk: assert property (@(posedge clk) disable iff (rst)
        pad_od |-> ((pad_oe & cfg_q.out_v) == '0 && pad_out == '0));
endmodule

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up, in_value;
    logic        pad_od;
    logic [15:0] pad_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the register bank
    logic [7:0] m_reg [0:8];

    always #5 clk = ~clk;

    gpio_port_bank u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .pad_drive(pad_drive), .in_value(in_value)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_oe();
        return ~m_reg[3] & (m_reg[8][0] ? ~m_reg[1] : 8'hFF);
    endfunction

    function automatic logic [7:0] exp_out();
        return m_reg[8][0] ? 8'h00 : m_reg[1];
    endfunction

    function automatic logic [15:0] exp_drive();
        logic [15:0] d;
        for (int i = 0; i < 8; i++) d[2*i +: 2] = {m_reg[5][i], m_reg[4][i]};
        return d;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        if (a == 4'd0) return m_reg[0] ^ m_reg[2];
        if (a <= 4'd8) return m_reg[a];
        return 8'h00;
    endfunction

    task automatic check_pads();
        check("R5/R6 pad_oe", {24'd0, pad_oe}, {24'd0, exp_oe()});
        check("R5/R6 pad_out", {24'd0, pad_out}, {24'd0, exp_out()});
        check("R6 pad_od", {31'd0, pad_od}, {31'd0, m_reg[8][0]});
        check("R7 pad_drive", {16'd0, pad_drive}, {16'd0, exp_drive()});
        check("R8 pad_pull_en", {24'd0, pad_pull_en}, {24'd0, m_reg[6]});
        check("R8 pad_pull_up", {24'd0, pad_pull_up}, {24'd0, m_reg[7]});
        check("R3 in_value", {24'd0, in_value}, {24'd0, m_reg[0] ^ m_reg[2]});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a >= 4'd1 && a <= 4'd7) m_reg[a] = d;
        else if (a == 4'd8) m_reg[8] = {7'd0, d[0]};
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, {24'd0, reg_rdata}, {24'd0, exp_rd(a)});
    endtask

    task automatic set_pads(input logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        @(negedge clk);
        m_reg[0] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd2024);
        m_reg[0] = 8'h00; m_reg[1] = 8'hFF; m_reg[2] = 8'h00; m_reg[3] = 8'hFF;
        m_reg[4] = 8'hFF; m_reg[5] = 8'hFF; m_reg[6] = 8'h00; m_reg[7] = 8'hFF;
        m_reg[8] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe after reset", {24'd0, pad_oe}, 32'h0);
        check_pads();
        for (int a = 0; a < 9; a++) rd(a[3:0], "R1 reset readback");

        // R3 polarity on input path
        set_pads(8'hA5);
        wr(4'd2, 8'h0F);
        check("R3 in_value inverted", {24'd0, in_value}, 32'hAA);
        rd(4'd0, "R3 input read");

        // R4 write to input address ignored
        wr(4'd0, 8'h3C);
        rd(4'd0, "R4 input after write");
        for (int a = 1; a < 9; a++) rd(a[3:0], "R4 regs after input write");

        // R5 push-pull
        wr(4'd3, 8'h0F);
        wr(4'd1, 8'h05);
        check("R5 pp oe", {24'd0, pad_oe}, 32'hF0);
        check("R5 pp out", {24'd0, pad_out}, 32'h05);

        // R6 open-drain
        wr(4'd8, 8'hFF);
        check("R6 od oe", {24'd0, pad_oe}, 32'hF0);
        check("R6 od out", {24'd0, pad_out}, 32'h00);
        rd(4'd8, "R2 mode readback");
        wr(4'd1, 8'hF0);
        check("R6 od release", {24'd0, pad_oe}, 32'h00);

        // R7 drive codes
        wr(4'd4, 8'h5A);
        wr(4'd5, 8'h33);
        check("R7 drive", {16'd0, pad_drive}, {16'd0, exp_drive()});

        // R10 unmapped
        wr(4'd12, 8'h77);
        rd(4'd12, "R10 unmapped read");
        for (int a = 1; a < 9; a++) rd(a[3:0], "R10 regs after unmapped write");

        // R9 output persists through other traffic
        wr(4'd1, 8'h96);
        wr(4'd6, 8'hC3);
        wr(4'd7, 8'h18);
        rd(4'd2, "R2 pol read");
        rd(4'd1, "R9 output held");
        check_pads();

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [3:0] a;
            logic [7:0] d;
            op = $urandom % 10;
            a  = 4'($urandom % 16);
            d  = 8'($urandom);
            if (op < 4)       wr(a, d);
            else if (op < 8)  rd(a, "R2 random read");
            else              set_pads(d);
            check_pads();
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule